// File: doc/BRIEF.md
# Multi-block card transfer sequencer

This block paces the data phase of a memory-card transfer. Software programs a transfer kind (one block, several blocks, or a stream), the size of a block and, for multi-block work, how many blocks to move, then issues a start command. While the transfer runs, a line engine reports each byte it moves with a one-cycle valid strobe. The sequencer counts bytes inside the current block and counts finished blocks. From these counts it decides when the transfer is over.

A counted transfer stops by itself once the last block is done, and it asks for no stop command. A multi-block transfer whose count is zero is open-ended. It ends only after software issues a stop command, and that command takes effect at the next block boundary. A stream transfer ignores block boundaries and ends as soon as software stops it. An error reported by the line engine aborts a transfer of any kind. Whenever a transfer ends through a stop command or an error, the sequencer sends a one-cycle stop request to the command path. Every ending raises an end-of-transfer flag that software can poll, and an interrupt line that can be masked.

Top module: `blk_xfer_seq`

## Requirements
- R1: After a synchronous reset, busy, eot, irq and stop_req are 0 and blk_cnt is 0.
- R2: The configuration port is write-only and the write address selects the target:
  - Address 0 holds the transfer kind in bits [1:0] (0 = single block, 1 = multi block, 2 = stream, 3 = treated as multi block) and the interrupt enable in bit 4.
  - Address 1 holds the block length minus one in bits [LEN_W-1:0].
  - Address 2 holds the block count in bits [15:0].
  - Address 3 is the command register: bit 0 starts a transfer and bit 1 stops one.
  - A start command written while busy is 1 is ignored.
- R3: A byte is accepted in any cycle where byte_vld is 1, busy is 1 and err_in is 0. After every (length minus one + 1) accepted bytes, blk_cnt increments by one. Both counters clear when a transfer starts.
- R4: A single-block transfer ends after one block, whatever value the count register holds. It raises no stop_req.
- R5: A multi-block transfer with a nonzero count N ends in the cycle after the last byte of block N, with blk_cnt = N and no stop_req. A stop command has no effect on such a transfer.
- R6: A multi-block transfer with count 0 keeps running across block boundaries. After a stop command, it ends in the cycle after the last byte of the current block and raises stop_req for exactly one cycle.
- R7: A stream transfer does not end at block boundaries. A stop command ends it in the next cycle and raises stop_req for exactly one cycle.
- R8: If err_in is 1 while busy is 1, the transfer ends in the next cycle with eot set and a one-cycle stop_req, whatever the transfer kind.
- R9: eot becomes 1 when a transfer ends and stays 1 until the next accepted start clears it. irq equals eot AND the interrupt enable, and the enable may be changed at any time.
- R10: The kind, length and count are captured at start. Writing them during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| byte_vld | input | 1 | One byte moved by the line engine this cycle |
| err_in | input | 1 | Transfer error reported by the line engine |
| busy | output | 1 | Transfer in progress; the line engine may move bytes |
| blk_cnt | output | 16 | Blocks completed in the current or last transfer |
| eot | output | 1 | End-of-transfer status |
| irq | output | 1 | End-of-transfer interrupt |
| stop_req | output | 1 | One-cycle request for a stop command |

## Verification
The bench sets a count register to a large value and then runs a single-block transfer. A design that honoured that count would stay busy past the first block. The bench issues a stop in the middle of a block, in open-ended mode and then in stream mode. A design that ignored the block boundary would end the open-ended transfer early, and one that waited for a boundary would hang the stream transfer. The bench also issues a stop during a counted transfer, restarts while busy, and rewrites length and count during a transfer. Any of these can wrongly shorten, extend or reset the transfer, and any of them can raise a stop request that should not appear. A final check ends a counted transfer with an error, which must still request a stop.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    XT_SINGLE = 2'd0,
    XT_MULTI  = 2'd1,
    XT_STREAM = 2'd2,
    XT_RSVD   = 2'd3
  } xfer_kind_e;

  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_LEN   = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;
  localparam logic [1:0] A_CMD   = 2'd3;

  localparam int B_IEN   = 4;
  localparam int B_START = 0;
  localparam int B_STOP  = 1;
endpackage

// File: rtl/blk_xfer_cfg.sv
module blk_xfer_cfg
  import blk_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output xfer_kind_e        kind_q,
  output logic              ien_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start_p,
  output logic              stop_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= XT_SINGLE;
      ien_q  <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else if (we) begin
      case (addr)
        A_MODE: begin
          kind_q <= xfer_kind_e'(wdata[1:0]);
          ien_q  <= wdata[B_IEN];
        end
        A_LEN:   len_q <= wdata[LEN_W-1:0];
        A_COUNT: cnt_q <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign start_p = we && (addr == A_CMD) && wdata[B_START];
  assign stop_p  = we && (addr == A_CMD) && wdata[B_STOP];
endmodule

// File: rtl/blk_xfer_cnt.sv
module blk_xfer_cnt #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [LEN_W-1:0] len_m1,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [CNT_W-1:0] blk_cnt,
  output logic             blk_end
);
  assign blk_end = step && (byte_cnt == len_m1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      byte_cnt <= '0;
      blk_cnt  <= '0;
    end else if (step) begin
      if (blk_end) begin
        byte_cnt <= '0;
        blk_cnt  <= blk_cnt + 1'b1;
      end else begin
        byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= len_m1); // R3
  AST_BLK_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(blk_cnt)); // R3
endmodule

// File: rtl/blk_xfer_ctl.sv
module blk_xfer_ctl
  import blk_xfer_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             err_in,
  input  logic             blk_end,
  input  logic [CNT_W-1:0] blk_cnt,
  input  xfer_kind_e       cfg_kind,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [CNT_W-1:0] cfg_cnt,
  output logic             clr,
  output logic             busy,
  output logic             eot,
  output logic             stop_req,
  output logic [LEN_W-1:0] act_len
);
  logic             counted, streaming, stop_pend;
  logic [CNT_W-1:0] target;
  logic             last_blk;

  assign clr      = start_p && !busy;
  assign last_blk = ({1'b0, blk_cnt} + 1'b1) == {1'b0, target};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      eot       <= 1'b0;
      stop_req  <= 1'b0;
      stop_pend <= 1'b0;
      counted   <= 1'b0;
      streaming <= 1'b0;
      target    <= '0;
      act_len   <= '0;
    end else begin
      stop_req <= 1'b0;
      if (!busy) begin
        if (start_p) begin
          busy      <= 1'b1;
          eot       <= 1'b0;
          stop_pend <= 1'b0;
          act_len   <= cfg_len;
          streaming <= (cfg_kind == XT_STREAM);
          counted   <= (cfg_kind == XT_SINGLE) ||
                       ((cfg_kind != XT_STREAM) && (cfg_cnt != '0));
          target    <= (cfg_kind == XT_SINGLE) ? CNT_W'(1) : cfg_cnt;
        end
      end else if (err_in) begin
        busy     <= 1'b0;
        eot      <= 1'b1;
        stop_req <= 1'b1;
      end else if (streaming && stop_p) begin
        busy     <= 1'b0;
        eot      <= 1'b1;
        stop_req <= 1'b1;
      end else if (blk_end && counted && last_blk) begin
        busy <= 1'b0;
        eot  <= 1'b1;
      end else if (blk_end && !counted && !streaming && (stop_pend || stop_p)) begin
        busy     <= 1'b0;
        eot      <= 1'b1;
        stop_req <= 1'b1;
      end else if (stop_p && !counted) begin
        stop_pend <= 1'b1;
      end
    end
  end

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !stop_req); // R6
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> (!busy && eot)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (busy && !eot)); // R9
  AST_BLK_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (busy && counted) |-> (blk_cnt < target)); // R5
  AST_COUNTED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busy && counted && !err_in) |=> !stop_req); // R5
  AST_EOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eot && !clr) |=> eot); // R9
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              byte_vld,
  input  logic              err_in,
  output logic              busy,
  output logic [CNT_W-1:0]  blk_cnt,
  output logic              eot,
  output logic              irq,
  output logic              stop_req
);
  xfer_kind_e       kind_q;
  logic             ien_q, start_p, stop_p, clr, step, blk_end;
  logic [LEN_W-1:0] len_q, act_len, byte_cnt;
  logic [CNT_W-1:0] cnt_q;

  blk_xfer_cfg #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .kind_q(kind_q), .ien_q(ien_q), .len_q(len_q), .cnt_q(cnt_q),
    .start_p(start_p), .stop_p(stop_p));

  assign step = busy && byte_vld && !err_in;

  blk_xfer_cnt #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .len_m1(act_len),
    .byte_cnt(byte_cnt), .blk_cnt(blk_cnt), .blk_end(blk_end));

  blk_xfer_ctl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .err_in(err_in), .blk_end(blk_end), .blk_cnt(blk_cnt),
    .cfg_kind(kind_q), .cfg_len(len_q), .cfg_cnt(cnt_q),
    .clr(clr), .busy(busy), .eot(eot), .stop_req(stop_req),
    .act_len(act_len));

  assign irq = eot && ien_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq); // R9
  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(byte_cnt) || (byte_cnt == '0)); // R3
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        byte_vld = 1'b0;
  logic        err_in = 1'b0;
  logic        busy, eot, irq, stop_req;
  logic [15:0] blk_cnt;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  blk_xfer_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .byte_vld(byte_vld), .err_in(err_in),
    .busy(busy), .blk_cnt(blk_cnt), .eot(eot), .irq(irq),
    .stop_req(stop_req));

  function automatic int exp_blocks(input int kind, input int cnt);
    return (kind == 0) ? 1 : cnt;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = 32'd0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1'b1;
    end
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic setup(input int kind, input int ien, input int lm1, input int cnt);
    wr(2'd0, 32'(kind) | (32'(ien) << 4));
    wr(2'd1, 32'(lm1));
    wr(2'd2, 32'(cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int kind, lm1, cnt, nb;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 eot", eot, 0); chk("R1 irq", irq, 0);
    chk("R1 stop_req", stop_req, 0); chk("R1 blk_cnt", blk_cnt, 0);

    // R4: single block ignores count register
    setup(0, 1, 3, 7);
    wr(2'd3, 32'h1);
    chk("R2 busy after start", busy, 1);
    send(3);
    chk("R4 still busy before last byte", busy, 1);
    send(1);
    chk("R4 ended", busy, 0); chk("R4 blk_cnt", blk_cnt, 1);
    chk("R4 no stop_req", stop_req, 0); chk("R9 eot", eot, 1);
    chk("R9 irq", irq, 1);
    wr(2'd0, 32'h0);
    chk("R9 irq masked", irq, 0); chk("R9 eot held", eot, 1);

    // r5_ random counted transfers
    for (int t = 0; t < 20; t++) begin
      kind = ($urandom % 2);
      lm1 = $urandom % 6;
      cnt = 1 + ($urandom % 5);
      nb = exp_blocks(kind, cnt);
      setup(kind, 0, lm1, cnt);
      wr(2'd3, 32'h1);
      chk("R9 start clears eot", eot, 0);
      send(nb * (lm1 + 1) - 1);
      chk("R5 busy before final byte", busy, 1);
      chk("R3 blk_cnt mid", blk_cnt, nb - 1);
      send(1);
      chk("R5 ended", busy, 0); chk("R5 blk_cnt", blk_cnt, nb);
      chk("R5 no stop_req", stop_req, 0);
    end

    // R5 stop ignored, R2 restart ignored, R10 capture
    setup(1, 0, 3, 2);
    wr(2'd3, 32'h1);
    send(5);
    wr(2'd3, 32'h2);
    wr(2'd3, 32'h1);
    wr(2'd1, 32'd0); wr(2'd2, 32'd9); wr(2'd0, 32'd2);
    chk("R5 stop ignored", busy, 1);
    chk("R2 restart ignored blk_cnt", blk_cnt, 1);
    send(2);
    chk("R10 still busy", busy, 1);
    send(1);
    chk("R10 ended after captured count", busy, 0);
    chk("R10 blk_cnt", blk_cnt, 2); chk("R5 no stop_req", stop_req, 0);

    // R6 open-ended, stop mid-block
    setup(1, 1, 4, 0);
    wr(2'd3, 32'h1);
    send(12);
    chk("R6 runs past boundaries", busy, 1);
    wr(2'd3, 32'h2);
    chk("R6 waits for boundary", busy, 1); chk("R6 no early stop", stop_req, 0);
    send(2);
    chk("R6 busy before boundary", busy, 1);
    @(negedge clk); byte_vld = 1'b1;
    @(negedge clk); byte_vld = 1'b0;
    chk("R6 ended at boundary", busy, 0); chk("R6 stop_req", stop_req, 1);
    chk("R6 blk_cnt", blk_cnt, 3); chk("R9 irq", irq, 1);
    @(negedge clk);
    chk("R6 stop_req one cycle", stop_req, 0);

    // R7 stream
    setup(2, 0, 1, 3);
    wr(2'd3, 32'h1);
    send(9);
    chk("R7 no end at boundaries", busy, 1);
    chk("R3 stream blk_cnt", blk_cnt, 4);
    wr(2'd3, 32'h2);
    chk("R7 ended", busy, 0); chk("R7 stop_req", stop_req, 1);
    @(negedge clk);
    chk("R7 stop_req one cycle", stop_req, 0);

    // R8 error on counted multi
    setup(1, 0, 2, 4);
    wr(2'd3, 32'h1);
    send(4);
    @(negedge clk); err_in = 1'b1;
    @(negedge clk); err_in = 1'b0;
    chk("R8 ended", busy, 0); chk("R8 stop_req", stop_req, 1);
    chk("R8 eot", eot, 1); chk("R8 blk_cnt", blk_cnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule